// File: doc/BRIEF.md
# Flash Read-State and Status Controller

This block is the command side of a NOR-style flash device model. Each command byte written on the command port is decoded. Some bytes choose what a read access returns: the memory array, the identifier words, the status byte or the query table. Other bytes start a program or erase, and one clears the error flags. The chosen read state is presented as a 2-bit code, which a neighbouring read-path multiplexer uses to steer the data bus.

The block also holds the 8-bit status byte that a simple write-state-machine stub updates. Three kinds of bit live in it:
- The ready bit and the two suspend bits are live. The stub drives them both up and down.
- The three error bits are sticky. An event pulse sets them, and only the clear command or reset removes them.

Once a program or erase has started, the block stays in the status read state. It goes back to array reads only when the array read command is written. A finishing operation never switches it back by itself.

Top module: `flash_rdstate_ctrl`

## Requirements
- R1: Read state codes are array = 0, identifier = 1, status = 2 and query = 3. While the ready bit (status bit 7) is 1, the codes take effect one cycle after the write: 0xFF selects array, 0x90 identifier, 0x70 status and 0x98 query.
- R2: Synchronous reset selects the array state (0) and sets the status byte to 0x80. Reset clears every error bit.
- R3: A written code other than 0xFF, 0x90, 0x70, 0x98, 0x40, 0x20 and 0x50 changes neither the read state nor the status byte.
- R4: While ready, writing 0x40 (program) or 0x20 (erase) moves to the status read state (2) and clears status bit 7 one cycle later.
- R5: While status bit 7 is 0 (busy), every command write is ignored, including 0xFF and 0x50.
- R6: A pulse on `op_done` sets status bit 7 one cycle later. The read state remains status (2) until 0xFF is written.
- R7: Pulses on `op_err[2]`, `op_err[1]` and `op_err[0]` set status bits 5, 3 and 1. These bits stay set through later operations, including successful ones.
- R8: Writing 0x50 while ready clears status bits 5, 3 and 1 one cycle later and leaves the read state unchanged. If an error pulse arrives in the same cycle as the clear, that error bit ends up set.
- R9: Status bits 6 and 2 follow the `erase_susp` and `prog_susp` inputs with one cycle of latency. Status bits 4 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe, one byte per cycle |
| cmd_byte | input | 8 | Command code |
| op_done | input | 1 | Stub pulse: program or erase finished |
| op_err | input | 3 | Stub pulses: error events for status bits 5, 3 and 1 |
| erase_susp | input | 1 | Stub level: erase suspended |
| prog_susp | input | 1 | Stub level: program suspended |
| rd_state | output | 2 | Current read state code |
| status | output | 8 | Status byte |

## Verification
Two pairs of events can fall in the same cycle:
- a clear command with an error pulse;
- a busy-time command write with the done pulse that ends the busy period.

Directed cases line up each pair on one clock edge. A clear that coincides with an error pulse must leave that error bit set. A write that coincides with done must still be ignored, because the block was busy at that edge. Random traffic then produces many more of these coincidences, and every cycle is judged against a bench model of the read state and status byte built from the requirements.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W   = 8;
    localparam int NUM_ERR = 3;
    localparam int SR_W    = 8;

    localparam int SR_READY = 7;
    localparam int SR_ESUSP = 6;
    localparam int SR_PSUSP = 2;

    localparam logic [CMD_W-1:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_RD_IDENT = 8'h90;
    localparam logic [CMD_W-1:0] CMD_RD_STAT  = 8'h70;
    localparam logic [CMD_W-1:0] CMD_RD_QUERY = 8'h98;
    localparam logic [CMD_W-1:0] CMD_PROGRAM  = 8'h40;
    localparam logic [CMD_W-1:0] CMD_ERASE    = 8'h20;
    localparam logic [CMD_W-1:0] CMD_CLR_STAT = 8'h50;

    typedef enum logic [1:0] {
        RS_ARRAY  = 2'd0,
        RS_IDENT  = 2'd1,
        RS_STATUS = 2'd2,
        RS_QUERY  = 2'd3
    } rd_state_e;

    typedef struct packed {
        logic      sel_valid;
        rd_state_e sel;
        logic      start;
        logic      clr;
    } cmd_dec_t;

    // Sticky error k maps to status bit 1, 3, 5
    function automatic int err_bit(input int k);
        return 1 + 2 * k;
    endfunction

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] b);
        cmd_dec_t d;
        d = '{sel_valid: 1'b0, sel: RS_ARRAY, start: 1'b0, clr: 1'b0};
        case (b)
            CMD_RD_ARRAY: begin d.sel_valid = 1'b1; d.sel = RS_ARRAY;  end
            CMD_RD_IDENT: begin d.sel_valid = 1'b1; d.sel = RS_IDENT;  end
            CMD_RD_STAT:  begin d.sel_valid = 1'b1; d.sel = RS_STATUS; end
            CMD_RD_QUERY: begin d.sel_valid = 1'b1; d.sel = RS_QUERY;  end
            CMD_PROGRAM,
            CMD_ERASE:    begin d.start = 1'b1; d.sel = RS_STATUS; end
            CMD_CLR_STAT: d.clr = 1'b1;
            default:      ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             ready,
    output cmd_dec_t         acc
);
    cmd_dec_t raw;

    always_comb begin
        raw = decode_cmd(cmd_byte);
        acc = raw;
        if (!(cmd_wr && ready)) begin
            acc.sel_valid = 1'b0;
            acc.start     = 1'b0;
            acc.clr       = 1'b0;
        end
    end

    // R5: nothing is accepted while busy
    assert_busy_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !(acc.sel_valid || acc.start || acc.clr));

    // R3: at most one action per accepted byte
    assert_one_action_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({acc.sel_valid, acc.start, acc.clr}));

endmodule

// File: rtl/flash_rdstate_fsm.sv
module flash_rdstate_fsm
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmd_dec_t  acc,
    output rd_state_e rd_state
);
    rd_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_ARRAY;
        end else if (acc.sel_valid || acc.start) begin
            state_q <= acc.sel;
        end
    end

    assign rd_state = state_q;

    // R4: program/erase start lands in status read
    assert_start_status_R4: assert property (@(posedge clk) disable iff (rst)
        acc.start |=> (rd_state == RS_STATUS));

    // R3: no selecting action keeps the state
    assert_hold_state_R3: assert property (@(posedge clk) disable iff (rst)
        !(acc.sel_valid || acc.start) |=> $stable(rd_state));

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               clr,
    input  logic               done,
    input  logic [NUM_ERR-1:0] err,
    input  logic               erase_susp,
    input  logic               prog_susp,
    output logic [SR_W-1:0]    status
);
    logic               ready_q;
    logic               esusp_q;
    logic               psusp_q;
    logic [NUM_ERR-1:0] sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b1;
            esusp_q <= 1'b0;
            psusp_q <= 1'b0;
        end else begin
            esusp_q <= erase_susp;
            psusp_q <= prog_susp;
            if (start) begin
                ready_q <= 1'b0;
            end else if (done) begin
                ready_q <= 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NUM_ERR; k++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) begin
                sticky_q[k] <= 1'b0;
            end else if (err[k]) begin
                sticky_q[k] <= 1'b1;
            end else if (clr) begin
                sticky_q[k] <= 1'b0;
            end
        end

        // R7: an error pulse always leaves its bit set
        assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
            err[k] |=> status[err_bit(k)]);
    end

    always_comb begin
        status           = '0;
        status[SR_READY] = ready_q;
        status[SR_ESUSP] = esusp_q;
        status[SR_PSUSP] = psusp_q;
        for (int k = 0; k < NUM_ERR; k++) begin
            status[err_bit(k)] = sticky_q[k];
        end
    end

    // R7: without a clear, set sticky bits never drop
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R8: a clear without error pulses empties the sticky bits
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && (err == '0)) |=> (sticky_q == '0));

    // R6: done sets ready unless a start coincides
    assert_done_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> status[SR_READY]);

endmodule

// File: rtl/flash_rdstate_ctrl.sv
module flash_rdstate_ctrl
    import flash_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_byte,
    input  logic               op_done,
    input  logic [NUM_ERR-1:0] op_err,
    input  logic               erase_susp,
    input  logic               prog_susp,
    output logic [1:0]         rd_state,
    output logic [SR_W-1:0]    status
);
    cmd_dec_t  acc;
    rd_state_e state_w;

    flash_cmd_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_byte (cmd_byte),
        .ready    (status[SR_READY]),
        .acc      (acc)
    );

    flash_rdstate_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .rd_state (state_w)
    );

    flash_status_reg u_sr (
        .clk        (clk),
        .rst        (rst),
        .start      (acc.start),
        .clr        (acc.clr),
        .done       (op_done),
        .err        (op_err),
        .erase_susp (erase_susp),
        .prog_susp  (prog_susp),
        .status     (status)
    );

    assign rd_state = state_w;

    // R2: reset state
    assert_reset_R2: assert property (@(posedge clk)
        rst |=> (rd_state == 2'd0 && status == 8'h80));

    // R5: busy writes leave the read state alone
    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !status[SR_READY]) |=> $stable(rd_state));

    // R9: bits 4 and 0 are always zero
    assert_zero_bits_R9: assert property (@(posedge clk) disable iff (rst)
        status[4] == 1'b0 && status[0] == 1'b0);

endmodule

// File: tb/flash_rdstate_ctrl_tb.sv
`timescale 1ns/1ps
module flash_rdstate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       op_done = 1'b0;
    logic [2:0] op_err = 3'b000;
    logic       erase_susp = 1'b0;
    logic       prog_susp = 1'b0;
    logic [1:0] rd_state;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0] m_state;
    logic [7:0] m_status;

    always #2.5 clk = ~clk;

    flash_rdstate_ctrl u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
        .op_done(op_done), .op_err(op_err), .erase_susp(erase_susp),
        .prog_susp(prog_susp), .rd_state(rd_state), .status(status)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model_update();
        logic busy;
        logic [7:0] s;
        if (rst) begin
            m_state  = 2'd0;
            m_status = 8'h80;
            return;
        end
        busy = !m_status[7];
        s = m_status;
        if (cmd_wr && !busy) begin
            case (cmd_byte)
                8'hFF: m_state = 2'd0;
                8'h90: m_state = 2'd1;
                8'h70: m_state = 2'd2;
                8'h98: m_state = 2'd3;
                8'h40, 8'h20: begin m_state = 2'd2; s[7] = 1'b0; end
                8'h50: begin s[5] = 1'b0; s[3] = 1'b0; s[1] = 1'b0; end
                default: ;
            endcase
        end
        if (!(cmd_wr && !busy && (cmd_byte == 8'h40 || cmd_byte == 8'h20)) && op_done)
            s[7] = 1'b1;
        if (op_err[0]) s[1] = 1'b1;
        if (op_err[1]) s[3] = 1'b1;
        if (op_err[2]) s[5] = 1'b1;
        s[6] = erase_susp;
        s[2] = prog_susp;
        m_status = s;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        cmd_wr = 1'b1; cmd_byte = b;
        step();
        cmd_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        check("R2 reset state", {6'd0, rd_state}, 8'h00);
        check("R2 reset status", status, 8'h80);

        wr(8'h90); check("R1 ident", {6'd0, rd_state}, 8'h01);
        wr(8'h98); check("R1 query", {6'd0, rd_state}, 8'h03);
        wr(8'h70); check("R1 status", {6'd0, rd_state}, 8'h02);
        wr(8'hFF); check("R1 array", {6'd0, rd_state}, 8'h00);

        wr(8'hAA);
        check("R3 unknown state", {6'd0, rd_state}, 8'h00);
        check("R3 unknown status", status, 8'h80);

        wr(8'h40);
        check("R4 start state", {6'd0, rd_state}, 8'h02);
        check("R4 start busy", status, 8'h00);

        wr(8'hFF); check("R5 busy array ignored", {6'd0, rd_state}, 8'h02);
        op_err = 3'b001; step(); op_err = 3'b000;
        check("R7 err bit1", status, 8'h02);
        wr(8'h50); check("R5 busy clear ignored", status, 8'h02);

        // done coincides with a busy-time write: write still ignored
        op_done = 1'b1; cmd_wr = 1'b1; cmd_byte = 8'h90;
        step();
        op_done = 1'b0; cmd_wr = 1'b0;
        check("R6 ready set", status, 8'h82);
        check("R5 write with done ignored", {6'd0, rd_state}, 8'h02);

        wr(8'h20);
        op_done = 1'b1; step(); op_done = 1'b0;
        check("R7 sticky survives success", status, 8'h82);
        check("R6 stays status", {6'd0, rd_state}, 8'h02);
        wr(8'hFF); check("R6 array by command", {6'd0, rd_state}, 8'h00);

        wr(8'h50);
        check("R8 clear", status, 8'h80);
        check("R8 state unchanged", {6'd0, rd_state}, 8'h00);

        op_err = 3'b101; cmd_wr = 1'b1; cmd_byte = 8'h50;
        step();
        op_err = 3'b000; cmd_wr = 1'b0;
        check("R8 set wins over clear", status, 8'hA2);

        erase_susp = 1'b1; step();
        check("R9 erase susp", status, 8'hE2);
        prog_susp = 1'b1; erase_susp = 1'b0; step();
        check("R9 prog susp", status, 8'hA6);
        prog_susp = 1'b0; step();

        rst = 1'b1; step(); rst = 1'b0;
        check("R2 reset clears sticky", status, 8'h80);

        for (int i = 0; i < 3000; i++) begin
            int sel;
            cmd_wr = ($urandom % 4) == 0;
            sel = $urandom % 9;
            case (sel)
                0: cmd_byte = 8'hFF;
                1: cmd_byte = 8'h90;
                2: cmd_byte = 8'h70;
                3: cmd_byte = 8'h98;
                4: cmd_byte = 8'h40;
                5: cmd_byte = 8'h20;
                6: cmd_byte = 8'h50;
                default: cmd_byte = 8'($urandom);
            endcase
            op_done = ($urandom % 6) == 0;
            op_err = {($urandom % 16) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0};
            if (($urandom % 20) == 0) erase_susp = ~erase_susp;
            if (($urandom % 20) == 0) prog_susp = ~prog_susp;
            rst = ($urandom % 500) == 0;
            step();
            check("R1 random state", {6'd0, rd_state}, {6'd0, m_state});
            check("R7 random status", status, m_status);
        end
        finish_run();
    end

endmodule